// File: doc/BRIEF.md
# Prescaled Dual Counter Timer

This block holds two independent down-counting timers. Each timer is a 6-bit prescaler followed by an 8-bit counter, and each has its own registers for the initial values. A timer raises its interrupt line for one cycle when the prescaler and the counter both reach their end of count. After that it either stops at zero or reloads its initial values and keeps counting.

Timer 0 counts only the internal clock enable divided by four. Timer 1 can count the same divided enable or use an external input. The external input can act as a clock, as a gate on the divided enable, or as a trigger. A trigger can be retriggerable or non-retriggerable. The external input passes through a two-flop synchronizer, and its rising edge marks an event.

Software writes the initial values and the control word through a simple write port. It reads either live counter value through a read port, and a read has no side effects.

Top module: `dual_ctimer`

## Requirements
- R1: Timer 0 counts one event for every fourth high cycle of `tick_i`. With prescale P (address 1, bits 5:0) and count C (address 0), continuous Timer 0 interrupts every 4*P*C cycles when `tick_i` is held high. While `tick_i` is low, the count does not change.
- R2: A prescale field of 0 divides by 64. A count value of 0 counts 256 prescaler periods.
- R3: `irq0_o` (Timer 0) and `irq1_o` (Timer 1) are one-cycle pulses. Each pulse is raised only on the event that ends both the prescaler and the counter, which is the event that finds the count at 1.
- R4: When the mode bit (bit 7 of address 1 or 3) is 0, the timer runs a single pass. After its interrupt the count reads 0, and further events cause no interrupt until the next restart.
- R5: When the mode bit is 1, the timer is continuous. The count reloads its initial value on each interrupt and counting goes on.
- R6: In the control word at address 4, bit 0 is Timer 0 run and bit 2 is Timer 1 run. Clearing the run bit freezes the count. Setting it again resumes from the frozen value.
- R7: Writing 1 to control bit 1 (Timer 0) or bit 3 (Timer 1) restarts that timer. The restart loads both initial values, and the count reads the initial value on the next cycle.
- R8: `rd_data` shows the Timer 0 count when `rd_sel` is 0 and the Timer 1 count when it is 1. Reading does not alter either count.
- R9: Control bits 5:4 = 01 select external clock for Timer 1. Each rising edge of `ext_i` is one event.
- R10: Control bits 5:4 = 10 select gate mode. Timer 1 counts divided-by-four events only while `ext_i` is high and holds its count while `ext_i` is low.
- R11: Control bits 5:4 = 11 with bit 6 = 0 select non-retriggerable trigger mode. Timer 1 waits for a rising edge of `ext_i`, loads its initial values, and counts divided-by-four events. Edges during a pass are ignored. An edge after a single pass ends starts a new pass.
- R12: Control bits 5:4 = 11 with bit 6 = 1 select retriggerable trigger mode. Every rising edge of `ext_i` reloads the initial values of Timer 1.
- R13: In internal mode (bits 5:4 = 00), Timer 1 keeps the same 4*P*C timing as Timer 0, using the count at address 2 and the prescale at address 3. The Timer 1 source and `ext_i` activity have no effect on Timer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Internal clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 1 | Selects the timer whose count is read |
| rd_data | output | 8 | Current count of the selected timer |
| ext_i | input | 1 | External timer input (asynchronous) |
| irq0_o | output | 1 | Timer 0 end-of-count pulse |
| irq1_o | output | 1 | Timer 1 end-of-count pulse |

## Verification
The bench sweeps prescale and count pairs, including both zero encodings. It checks the exact cycle interval between interrupts, so an off-by-one at either end of the cascade or a missed 64 or 256 wrap shows up as a wrong period. It also stops, resumes and restarts timers mid-count. A design that reloaded on resume, or kept counting while stopped, would read a different value. For the external modes, it drives counted edges, gated windows, and second trigger edges during a pass. A trigger that reloads when it should not shows a count that rises again, and one that fails to re-arm after a single pass stays at zero.

// File: rtl/ctm_pkg.sv
package ctm_pkg;
  typedef enum logic [1:0] {
    SRC_INT  = 2'b00,
    SRC_ECLK = 2'b01,
    SRC_GATE = 2'b10,
    SRC_TRIG = 2'b11
  } t1_src_e;

  localparam logic [2:0] A_T0_CNT = 3'd0;
  localparam logic [2:0] A_T0_PRE = 3'd1;
  localparam logic [2:0] A_T1_CNT = 3'd2;
  localparam logic [2:0] A_T1_PRE = 3'd3;
  localparam logic [2:0] A_CTRL   = 3'd4;
endpackage

// File: rtl/ctm_tick_div.sv
module ctm_tick_div #(
  parameter int DIV_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic tick_o
);
  localparam logic [DIV_W-1:0] LAST = {DIV_W{1'b1}};

  logic [DIV_W-1:0] div_q, div_d;

  always_comb begin
    div_d = div_q;
    if (tick_i) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = tick_i & (div_q == LAST);
endmodule

// File: rtl/ctm_ext_sync.sv
module ctm_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign level_o = sh_q[STAGES-1];
  assign rise_o  = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ctm_chan.sv
module ctm_chan #(
  parameter int PRE_W = 6,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             go_i,
  input  logic             ev_i,
  input  logic             cont_i,
  input  logic [PRE_W-1:0] pre_init_i,
  input  logic [CNT_W-1:0] cnt_init_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o
);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, irq_q, irq_d;

  always_comb begin
    pre_d  = pre_q;
    cnt_d  = cnt_q;
    done_d = done_q;
    irq_d  = 1'b0;
    if (load_i) begin
      pre_d  = pre_init_i;
      cnt_d  = cnt_init_i;
      done_d = 1'b0;
    end else if (go_i && ev_i && !done_q) begin
      if (pre_q == PRE_ONE) begin
        pre_d = pre_init_i;
        if (cnt_q == CNT_ONE) begin
          irq_d = 1'b1;
          if (cont_i) begin
            cnt_d = cnt_init_i;
          end else begin
            cnt_d  = '0;
            done_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end else begin
        pre_d = pre_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      irq_q  <= irq_d;
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/dual_ctimer.sv
module dual_ctimer #(
  parameter int PRE_W       = 6,
  parameter int CNT_W       = 8,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              ext_i,
  output logic              irq0_o,
  output logic              irq1_o
);
  import ctm_pkg::*;

  localparam int NCH = 2;

  logic [CNT_W-1:0] cnt_init_q [NCH];
  logic [CNT_W-1:0] cnt_init_d [NCH];
  logic [PRE_W-1:0] pre_init_q [NCH];
  logic [PRE_W-1:0] pre_init_d [NCH];
  logic [NCH-1:0]   cont_q, cont_d, run_q, run_d, restart;
  t1_src_e          src_q, src_d;
  logic             retrig_q, retrig_d, active_q, active_d;

  logic             tick4, ext_lvl, ext_rise, trig_mode, accept;
  logic [NCH-1:0]   ev, go, ld, irq_w;
  logic [CNT_W-1:0] cnt_w [NCH];

  always_comb begin
    cnt_init_d = cnt_init_q;
    pre_init_d = pre_init_q;
    cont_d     = cont_q;
    run_d      = run_q;
    src_d      = src_q;
    retrig_d   = retrig_q;
    restart    = '0;
    if (wr_en) begin
      case (wr_addr)
        A_T0_CNT: cnt_init_d[0] = wr_data;
        A_T1_CNT: cnt_init_d[1] = wr_data;
        A_T0_PRE: begin
          pre_init_d[0] = wr_data[PRE_W-1:0];
          cont_d[0]     = wr_data[CNT_W-1];
        end
        A_T1_PRE: begin
          pre_init_d[1] = wr_data[PRE_W-1:0];
          cont_d[1]     = wr_data[CNT_W-1];
        end
        A_CTRL: begin
          run_d[0]   = wr_data[0];
          restart[0] = wr_data[1];
          run_d[1]   = wr_data[2];
          restart[1] = wr_data[3];
          src_d      = t1_src_e'(wr_data[5:4]);
          retrig_d   = wr_data[6];
        end
        default: ;
      endcase
    end
  end

  ctm_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .tick_o(tick4)
  );

  ctm_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_i), .level_o(ext_lvl), .rise_o(ext_rise)
  );

  assign trig_mode = (src_q == SRC_TRIG);
  assign accept    = trig_mode & ext_rise & run_q[1] & (retrig_q | ~active_q);

  always_comb begin
    active_d = active_q & ~restart[1] & ~(irq_w[1] & ~cont_q[1]);
    if (accept) active_d = 1'b1;
  end

  always_comb begin
    ev[0] = tick4;
    case (src_q)
      SRC_ECLK: ev[1] = ext_rise;
      SRC_GATE: ev[1] = tick4 & ext_lvl;
      default:  ev[1] = tick4;
    endcase
    go[0] = run_q[0];
    go[1] = run_q[1] & (~trig_mode | active_q);
    ld[0] = restart[0];
    ld[1] = restart[1] | accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        cnt_init_q[i] <= '0;
        pre_init_q[i] <= '0;
      end
      cont_q   <= '0;
      run_q    <= '0;
      src_q    <= SRC_INT;
      retrig_q <= 1'b0;
      active_q <= 1'b0;
    end else begin
      cnt_init_q <= cnt_init_d;
      pre_init_q <= pre_init_d;
      cont_q     <= cont_d;
      run_q      <= run_d;
      src_q      <= src_d;
      retrig_q   <= retrig_d;
      active_q   <= active_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    ctm_chan #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .load_i(ld[g]), .go_i(go[g]), .ev_i(ev[g]),
      .cont_i(cont_q[g]), .pre_init_i(pre_init_q[g]), .cnt_init_i(cnt_init_q[g]),
      .cnt_o(cnt_w[g]), .irq_o(irq_w[g])
    );
  end

  assign rd_data = rd_sel ? cnt_w[1] : cnt_w[0];
  assign irq0_o  = irq_w[0];
  assign irq1_o  = irq_w[1];
endmodule

// File: rtl/dual_ctimer_chk.sv
module dual_ctimer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             irq0,
  input logic             irq1,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] init0,
  input logic             cont0,
  input logic             run0,
  input logic             load0,
  input logic             go1,
  input logic             load1
);
  p_irq0_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |=> !irq0);
  p_irq1_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |=> !irq1);
  p_irq0_at_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq0 |-> $past(cnt0) == CNT_W'(1));
  p_irq1_at_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> $past(cnt1) == CNT_W'(1));
  p_single_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && !$past(cont0)) |-> cnt0 == '0);
  p_cont_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq0 && $past(cont0)) |-> cnt0 == $past(init0));
  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run0 && !load0) |=> $stable(cnt0));
  p_t1_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!go1 && !load1) |=> $stable(cnt1));
  p_no_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !load0) |=> $stable(cnt0));
endmodule

bind dual_ctimer dual_ctimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .irq0(irq0_o), .irq1(irq1_o),
  .cnt0(cnt_w[0]), .cnt1(cnt_w[1]), .init0(cnt_init_q[0]), .cont0(cont_q[0]),
  .run0(run_q[0]), .load0(restart[0]), .go1(go[1]), .load1(ld[1])
);

// File: tb/dual_ctimer_bench.sv
module dual_ctimer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n, tick_i, wr_en, rd_sel, ext_i;
  logic [2:0] wr_addr;
  logic [7:0] wr_data, rd_data;
  logic       irq0_o, irq1_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n0 = 0, n1 = 0, t0p = 0, t0l = 0, t1p = 0, t1l = 0, pulse_bad = 0;
  logic irq0_prev = 1'b0, irq1_prev = 1'b0;

  dual_ctimer u_dual_ctimer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .ext_i(ext_i),
    .irq0_o(irq0_o), .irq1_o(irq1_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (irq0_o) begin n0++; t0p = t0l; t0l = cyc; end
    if (irq1_o) begin n1++; t1p = t1l; t1l = cyc; end
    if ((irq0_o && irq0_prev) || (irq1_o && irq1_prev)) pulse_bad++;
    irq0_prev = irq0_o;
    irq1_prev = irq1_o;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input bit s, output int v);
    rd_sel = s;
    #1;
    v = int'(rd_data);
  endtask

  task automatic pulse_ext();
    ext_i = 1'b1; waitc(4);
    ext_i = 1'b0; waitc(4);
  endtask

  task automatic t0_interval(input int p, input int c, input string req);
    int base, iv, exp;
    wr(4, 0); waitc(3);
    wr(0, c); wr(1, 8'h80 | p);
    base = n0;
    wr(4, 8'h03);
    while (n0 < base + 2) begin @(negedge clk); #1; end
    iv  = t0l - t0p;
    exp = 4 * ((p == 0) ? 64 : p) * ((c == 0) ? 256 : c);
    check(iv == exp, req, iv, exp);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int v, c1, c2, c3, base;
    rst_n = 1'b0; tick_i = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_sel = 1'b0; ext_i = 1'b0;
    waitc(5);
    rst_n = 1'b1;
    waitc(2);

    // reset state (R3, R8)
    check(irq0_o == 1'b0 && irq1_o == 1'b0, "R3 reset irq", int'(irq0_o) + int'(irq1_o), 0);
    rd(0, v); check(v == 0, "R8 reset count0", v, 0);
    rd(1, v); check(v == 0, "R8 reset count1", v, 0);

    // R1/R5: period sweep over prescale and count
    for (int p = 1; p <= 5; p++) begin
      if (p == 4) continue;
      for (int c = 1; c <= 7; c++) begin
        if (c == 4 || c == 5 || c == 6) continue;
        t0_interval(p, c, "R1 R5 period");
      end
    end
    // R2: zero encodings
    t0_interval(0, 3, "R2 prescale 0 means 64");
    t0_interval(1, 0, "R2 count 0 means 256");

    // R1: tick_i low freezes the count
    wr(4, 0); wr(0, 0); wr(1, 8'h81); wr(4, 8'h03);
    waitc(20);
    tick_i = 1'b0; waitc(2);
    rd(0, c1); waitc(100); rd(0, c2);
    check(c2 == c1, "R1 tick low holds", c2, c1);
    tick_i = 1'b1;

    // R4: single pass on Timer 0
    wr(4, 0); waitc(3);
    wr(0, 3); wr(1, 8'h02);
    base = n0;
    wr(4, 8'h03);
    waitc(100);
    check(n0 == base + 1, "R4 one interrupt", n0 - base, 1);
    rd(0, v); check(v == 0, "R4 count at zero", v, 0);
    waitc(100);
    check(n0 == base + 1, "R4 no further interrupt", n0 - base, 1);

    // R6, R7, R8: stop, resume, restart
    wr(0, 200); wr(1, 8'h01); wr(4, 8'h03);
    waitc(50);
    wr(4, 0);
    rd(0, c1); waitc(100); rd(0, c2);
    check(c2 == c1, "R6 R8 stopped count holds", c2, c1);
    wr(4, 8'h01);
    waitc(40);
    rd(0, c3);
    check(c3 <= c1 - 9 && c3 >= c1 - 11, "R6 resume from held count", c3, c1 - 10);
    wr(4, 8'h02);
    rd(0, v); check(v == 200, "R7 restart loads initial", v, 200);
    waitc(20);
    rd(0, v); check(v == 200, "R7 restarted but stopped", v, 200);

    // R13: Timer 1 internal period
    wr(4, 0); waitc(3);
    wr(2, 2); wr(3, 8'h83);
    base = n1;
    wr(4, 8'h0C);
    while (n1 < base + 2) begin @(negedge clk); #1; end
    check(t1l - t1p == 24, "R13 T1 internal period", t1l - t1p, 24);

    // R13: Timer 0 unaffected by T1 external clock and ext_i activity
    wr(4, 0); waitc(3);
    wr(0, 5); wr(1, 8'h81);
    base = n0;
    wr(4, 8'h1F);
    fork
      begin
        repeat (40) begin ext_i = ~ext_i; waitc(3); end
      end
      begin
        while (n0 < base + 2) begin @(negedge clk); #1; end
      end
    join
    check(t0l - t0p == 20, "R13 T0 period with ext activity", t0l - t0p, 20);

    // R9: external clock mode
    wr(4, 0); ext_i = 1'b0; waitc(4);
    wr(2, 5); wr(3, 8'h01);
    base = n1;
    wr(4, 8'h1C);
    waitc(4);
    repeat (3) pulse_ext();
    waitc(4);
    rd(1, v); check(v == 2, "R9 three edges counted", v, 2);
    repeat (2) pulse_ext();
    waitc(4);
    rd(1, v); check(v == 0, "R9 end of count", v, 0);
    check(n1 == base + 1, "R9 R3 one interrupt", n1 - base, 1);
    pulse_ext(); waitc(4);
    rd(1, v); check(v == 0 && n1 == base + 1, "R4 T1 done ignores edges", v, 0);

    // R10: gate mode
    wr(4, 0); waitc(3);
    wr(2, 100); wr(3, 8'h01);
    wr(4, 8'h2C);
    waitc(40);
    rd(1, v); check(v == 100, "R10 gate low holds", v, 100);
    ext_i = 1'b1; waitc(40);
    rd(1, v); check(v >= 89 && v <= 92, "R10 gate high counts", v, 90);
    ext_i = 1'b0; waitc(6);
    rd(1, c1); waitc(40); rd(1, c2);
    check(c2 == c1, "R10 gate closed again holds", c2, c1);

    // R11: non-retriggerable trigger
    wr(4, 0); waitc(3);
    wr(2, 50); wr(3, 8'h01);
    base = n1;
    wr(4, 8'h3C);
    waitc(40);
    rd(1, v); check(v == 50, "R11 waits for trigger", v, 50);
    pulse_ext(); waitc(32);
    rd(1, c1); check(c1 < 50 && c1 >= 38, "R11 trigger starts count", c1, 41);
    pulse_ext(); waitc(4);
    rd(1, c2); check(c2 < c1, "R11 second edge ignored", c2, c1 - 3);
    waitc(250);
    rd(1, v); check(v == 0 && n1 == base + 1, "R11 single pass ends", v, 0);
    pulse_ext(); waitc(4);
    rd(1, c3); check(c3 < 50 && c3 >= 45, "R11 re-armed after pass", c3, 48);

    // R12: retriggerable trigger
    wr(4, 0); waitc(3);
    wr(4, 8'h7C);
    pulse_ext(); waitc(40);
    rd(1, c1); check(c1 < 45 && c1 >= 30, "R12 counting after trigger", c1, 38);
    pulse_ext();
    rd(1, c2); check(c2 >= 48 && c2 > c1, "R12 second edge reloads", c2, 49);

    // R3: every interrupt was a single-cycle pulse
    check(pulse_bad == 0, "R3 pulse width", pulse_bad, 0);

    summary();
    $finish;
  end
endmodule